// File: doc/BRIEF.md
# Clock Enable Slot Generator

This block keeps a whole retro-computer core on one fast master clock. It does not make any derived clocks. A free-running position counter splits every slow system cycle into a fixed number of master clocks. From that counter the block decodes a set of single-clock enable strobes. There are two phase enables for the processor and two enables for the video generator. The memory controller gets a strobe on the first clock of every memory slot, together with the slot number. A pixel enable, whose rate is picked by a mode input, drives the video shift path. Every strobe comes from the same counter, so all of them keep a fixed alignment inside each system cycle.

By default the master clock is 160 MHz and the system cycle is 5 MHz. One system cycle is therefore 32 master clocks, split into eight 4-clock memory slots. Consumers gate their registers with these strobes and run on the master clock.

The block carries no data stream, so it has no valid/ready handshake. All pins are plain control signals that are sampled or driven on every clock.

Top module: `clk_en_slot_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the following cycle shows every strobe low, `cycle_pos` = 0 and `slot_idx` = 0.
- R2: In the first cycle after `rst` is seen low, `cycle_pos` is 0 and `cpu_ph1_en`, `slot_en` and `pix_en` are all high, so slot 0 opens on the first enabled cycle.
- R3: From then on, `cycle_pos` rises by one per clock and wraps from 31 to 0, giving a 32-clock system cycle.
- R4: `cpu_ph1_en` is high only when `cycle_pos` = 0 and `cpu_ph2_en` only when `cycle_pos` = 16. Each is high for one clock per system cycle, and no two of the four phase strobes are ever high together.
- R5: `vid_a_en` is high only when `cycle_pos` = 8 and `vid_b_en` only when `cycle_pos` = 24, each for one clock per system cycle.
- R6: `slot_en` is high on the first clock of each 4-clock slot, which is when `cycle_pos` mod 4 = 0. `slot_idx` always equals `cycle_pos` bits [4:2], counting 0 to 7 within a cycle.
- R7: With `hires` = 1 (40 MHz pixel rate), `pix_en` is high exactly when `cycle_pos` mod 4 = 0, which gives 8 pulses per system cycle.
- R8: With `hires` = 0 (20 MHz pixel rate), `pix_en` is high exactly when `cycle_pos` mod 8 = 0, which gives 4 pulses per system cycle.
- R9: A change of `hires` affects `pix_en` in the same cycle it is applied. It leaves `cycle_pos` and all other strobes undisturbed.
- R10: Asserting `rst` part-way through a system cycle abandons that cycle. After release, the sequence restarts at position 0 with the same pattern as R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| hires | input | 1 | Pixel-rate select: 1 = 40 MHz, 0 = 20 MHz |
| cpu_ph1_en | output | 1 | Processor first-phase enable |
| cpu_ph2_en | output | 1 | Processor second-phase enable |
| vid_a_en | output | 1 | Video generator first enable |
| vid_b_en | output | 1 | Video generator second enable |
| slot_en | output | 1 | First clock of a memory slot |
| slot_idx | output | 3 | Number of the current memory slot |
| pix_en | output | 1 | Pixel enable at the selected rate |
| cycle_pos | output | 5 | Position within the system cycle |

## Verification
The hardest cases to reach from the ports are those that break alignment. One is a reset that lands in the middle of a system cycle. The other is a `hires` toggle on a clock where the two pixel rates disagree, such as position 4 or 12. The stimulus places a reset at position 13 and flips the mode at several off-grid positions, in both directions. A behavioural position model in the bench is compared with every output on every clock, including the first cycle after each release.

// File: rtl/ces_pkg.sv
package ces_pkg;
  localparam int unsigned CYCLE_CLKS_D = 32;
  localparam int unsigned SLOT_COUNT_D = 8;
  localparam int unsigned HI_DIV_D     = 4;
  localparam int unsigned LO_DIV_D     = 8;
  localparam int unsigned TAP_COUNT    = 4;

  typedef enum logic [1:0] {
    TAP_CPU_PH1 = 2'd0,
    TAP_CPU_PH2 = 2'd1,
    TAP_VID_A   = 2'd2,
    TAP_VID_B   = 2'd3
  } tap_e;

  // Position of each phase tap inside one system cycle.
  function automatic int unsigned tap_offset(input int unsigned idx,
                                             input int unsigned cycle);
    case (idx)
      0:       return 0;
      1:       return cycle / 2;
      2:       return cycle / 4;
      default: return (3 * cycle) / 4;
    endcase
  endfunction
endpackage

// File: rtl/ces_cycle_counter.sv
module ces_cycle_counter #(
  parameter int unsigned CYCLE_CLKS = 32,
  parameter int unsigned POS_W      = 5
) (
  input  logic             clk,
  input  logic             rst,
  output logic             live_o,
  output logic [POS_W-1:0] pos_o
);
  localparam logic [POS_W-1:0] LAST = POS_W'(CYCLE_CLKS - 1);

  logic             live_q;
  logic [POS_W-1:0] pos_q;

  // Position holds at 0 for the first live cycle, then advances.
  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= 1'b0;
      pos_q  <= '0;
    end else begin
      live_q <= 1'b1;
      if (live_q) begin
        if (pos_q == LAST) pos_q <= '0;
        else               pos_q <= pos_q + POS_W'(1);
      end
    end
  end

  assign live_o = live_q;
  assign pos_o  = pos_q;
endmodule

// File: rtl/ces_tap_decoder.sv
module ces_tap_decoder
  import ces_pkg::*;
#(
  parameter int unsigned CYCLE_CLKS = 32,
  parameter int unsigned POS_W      = 5,
  parameter int unsigned NTAPS      = 4
) (
  input  logic             live_i,
  input  logic [POS_W-1:0] pos_i,
  output logic [NTAPS-1:0] taps_o
);
  for (genvar g = 0; g < NTAPS; g++) begin : g_tap
    localparam logic [POS_W-1:0] OFF = POS_W'(tap_offset(g, CYCLE_CLKS));
    assign taps_o[g] = live_i && (pos_i == OFF);
  end
endmodule

// File: rtl/ces_slot_strobe.sv
module ces_slot_strobe #(
  parameter int unsigned SLOT_CLKS = 4,
  parameter int unsigned POS_W     = 5,
  parameter int unsigned SLOT_W    = 3
) (
  input  logic              live_i,
  input  logic [POS_W-1:0]  pos_i,
  output logic              slot_en_o,
  output logic [SLOT_W-1:0] slot_idx_o
);
  localparam int unsigned SH = $clog2(SLOT_CLKS);

  if (SH == 0) begin : g_unit_slot
    assign slot_en_o  = live_i;
    assign slot_idx_o = SLOT_W'(pos_i);
  end else begin : g_multi_slot
    assign slot_en_o  = live_i && (pos_i[SH-1:0] == '0);
    assign slot_idx_o = SLOT_W'(pos_i[POS_W-1:SH]);
  end
endmodule

// File: rtl/ces_pixel_gate.sv
module ces_pixel_gate #(
  parameter int unsigned POS_W  = 5,
  parameter int unsigned HI_DIV = 4,
  parameter int unsigned LO_DIV = 8
) (
  input  logic             live_i,
  input  logic             hires_i,
  input  logic [POS_W-1:0] pos_i,
  output logic             pix_en_o
);
  localparam logic [POS_W-1:0] HI_MASK = POS_W'(HI_DIV - 1);
  localparam logic [POS_W-1:0] LO_MASK = POS_W'(LO_DIV - 1);

  logic hi_hit, lo_hit;
  assign hi_hit   = (pos_i & HI_MASK) == '0;
  assign lo_hit   = (pos_i & LO_MASK) == '0;
  assign pix_en_o = live_i && (hires_i ? hi_hit : lo_hit);
endmodule

// File: rtl/clk_en_slot_gen.sv
module clk_en_slot_gen
  import ces_pkg::*;
#(
  parameter  int unsigned CYCLE_CLKS = CYCLE_CLKS_D,
  parameter  int unsigned SLOT_COUNT = SLOT_COUNT_D,
  parameter  int unsigned HI_DIV     = HI_DIV_D,
  parameter  int unsigned LO_DIV     = LO_DIV_D,
  localparam int unsigned POS_W      = $clog2(CYCLE_CLKS),
  localparam int unsigned SLOT_W     = (SLOT_COUNT > 1) ? $clog2(SLOT_COUNT) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hires,
  output logic              cpu_ph1_en,
  output logic              cpu_ph2_en,
  output logic              vid_a_en,
  output logic              vid_b_en,
  output logic              slot_en,
  output logic [SLOT_W-1:0] slot_idx,
  output logic              pix_en,
  output logic [POS_W-1:0]  cycle_pos
);
  localparam int unsigned SLOT_CLKS = CYCLE_CLKS / SLOT_COUNT;

  logic                 live;
  logic [POS_W-1:0]     pos;
  logic [TAP_COUNT-1:0] taps;

  ces_cycle_counter #(.CYCLE_CLKS(CYCLE_CLKS), .POS_W(POS_W)) u_cnt (
    .clk(clk), .rst(rst), .live_o(live), .pos_o(pos)
  );

  ces_tap_decoder #(.CYCLE_CLKS(CYCLE_CLKS), .POS_W(POS_W), .NTAPS(TAP_COUNT)) u_taps (
    .live_i(live), .pos_i(pos), .taps_o(taps)
  );

  ces_slot_strobe #(.SLOT_CLKS(SLOT_CLKS), .POS_W(POS_W), .SLOT_W(SLOT_W)) u_slot (
    .live_i(live), .pos_i(pos), .slot_en_o(slot_en), .slot_idx_o(slot_idx)
  );

  ces_pixel_gate #(.POS_W(POS_W), .HI_DIV(HI_DIV), .LO_DIV(LO_DIV)) u_pix (
    .live_i(live), .hires_i(hires), .pos_i(pos), .pix_en_o(pix_en)
  );

  assign cpu_ph1_en = taps[TAP_CPU_PH1];
  assign cpu_ph2_en = taps[TAP_CPU_PH2];
  assign vid_a_en   = taps[TAP_VID_A];
  assign vid_b_en   = taps[TAP_VID_B];
  assign cycle_pos  = pos;
endmodule

// File: rtl/ces_checker.sv
module ces_checker #(
  parameter int unsigned CYCLE_CLKS = 32,
  parameter int unsigned SLOT_COUNT = 8,
  parameter int unsigned HI_DIV     = 4,
  parameter int unsigned LO_DIV     = 8,
  parameter int unsigned POS_W      = 5,
  parameter int unsigned SLOT_W     = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              hires,
  input logic              cpu_ph1_en,
  input logic              cpu_ph2_en,
  input logic              vid_a_en,
  input logic              vid_b_en,
  input logic              slot_en,
  input logic [SLOT_W-1:0] slot_idx,
  input logic              pix_en,
  input logic [POS_W-1:0]  cycle_pos
);
  localparam int unsigned SLOT_CLKS = CYCLE_CLKS / SLOT_COUNT;
  localparam logic [POS_W-1:0] LAST = POS_W'(CYCLE_CLKS - 1);

  logic seen_q   = 1'b0;
  logic seen_d_q = 1'b0;
  always_ff @(posedge clk) begin
    seen_q   <= !rst;
    seen_d_q <= seen_q && !rst;
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!cpu_ph1_en && !cpu_ph2_en && !vid_a_en && !vid_b_en &&
             !slot_en && !pix_en && cycle_pos == '0 && slot_idx == '0));

  a_r2_first_live: assert property (@(posedge clk) disable iff (rst)
    (seen_q && !seen_d_q) |-> (cpu_ph1_en && slot_en && pix_en && cycle_pos == '0));

  a_r3_advance: assert property (@(posedge clk) disable iff (rst)
    (seen_q && cycle_pos != LAST) |=> cycle_pos == $past(cycle_pos) + POS_W'(1));

  a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
    (seen_q && cycle_pos == LAST) |=> cycle_pos == '0);

  a_r4_ph1_pos: assert property (@(posedge clk) disable iff (rst)
    cpu_ph1_en |-> (cycle_pos == '0));

  a_r4_ph2_pos: assert property (@(posedge clk) disable iff (rst)
    cpu_ph2_en |-> (32'(cycle_pos) == CYCLE_CLKS / 2));

  a_r4_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cpu_ph1_en, cpu_ph2_en, vid_a_en, vid_b_en}));

  a_r5_vid_a_pos: assert property (@(posedge clk) disable iff (rst)
    vid_a_en |-> (32'(cycle_pos) == CYCLE_CLKS / 4));

  a_r5_vid_b_pos: assert property (@(posedge clk) disable iff (rst)
    vid_b_en |-> (32'(cycle_pos) == (3 * CYCLE_CLKS) / 4));

  a_r6_slot_align: assert property (@(posedge clk) disable iff (rst)
    slot_en |-> ((32'(cycle_pos) % SLOT_CLKS) == 0 &&
                 32'(slot_idx) == 32'(cycle_pos) / SLOT_CLKS));

  a_r6_ph1_slot0: assert property (@(posedge clk) disable iff (rst)
    cpu_ph1_en |-> (slot_en && slot_idx == '0));

  a_r7_hi_grid: assert property (@(posedge clk) disable iff (rst)
    (hires && pix_en) |-> ((32'(cycle_pos) % HI_DIV) == 0));

  a_r8_lo_grid: assert property (@(posedge clk) disable iff (rst)
    (!hires && pix_en) |-> ((32'(cycle_pos) % LO_DIV) == 0));

  a_r9_ph1_pixel: assert property (@(posedge clk) disable iff (rst)
    cpu_ph1_en |-> pix_en);
endmodule

bind clk_en_slot_gen ces_checker #(
  .CYCLE_CLKS(CYCLE_CLKS), .SLOT_COUNT(SLOT_COUNT), .HI_DIV(HI_DIV),
  .LO_DIV(LO_DIV), .POS_W(POS_W), .SLOT_W(SLOT_W)
) chk_i (.*);

// File: tb/clk_en_slot_gen_tb.sv
module clk_en_slot_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CYC = 32;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hires = 1'b1;
  logic       cpu_ph1_en, cpu_ph2_en, vid_a_en, vid_b_en, slot_en, pix_en;
  logic [2:0] slot_idx;
  logic [4:0] cycle_pos;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  clk_en_slot_gen dut_i (
    .clk(clk), .rst(rst), .hires(hires),
    .cpu_ph1_en(cpu_ph1_en), .cpu_ph2_en(cpu_ph2_en),
    .vid_a_en(vid_a_en), .vid_b_en(vid_b_en),
    .slot_en(slot_en), .slot_idx(slot_idx),
    .pix_en(pix_en), .cycle_pos(cycle_pos)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference: position and live state.
  int m_pos      = 0;
  bit m_live     = 0;
  bit m_first    = 0;
  bit m_midreset = 0;
  bit last_hires = 1;

  always @(posedge clk) begin
    if (rst) begin
      if (m_live && m_pos != 0) m_midreset = 1;
      m_pos   = 0;
      m_live  = 0;
      m_first = 0;
    end else if (!m_live) begin
      m_live  = 1;
      m_first = 1;
    end else begin
      m_pos   = (m_pos + 1) % CYC;
      m_first = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at t=%0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      if (!m_live) begin
        // R1: quiet during reset
        chk({cpu_ph1_en, cpu_ph2_en, vid_a_en, vid_b_en, slot_en, pix_en} == 6'b0,
            "R1 strobes", {cpu_ph1_en, cpu_ph2_en, vid_a_en, vid_b_en, slot_en, pix_en}, 0);
        chk(cycle_pos == 0 && slot_idx == 0, "R1 position", cycle_pos, 0);
      end else begin
        if (m_first) begin
          chk(cpu_ph1_en && slot_en && pix_en && cycle_pos == 0, "R2 first live",
              {cpu_ph1_en, slot_en, pix_en}, 7);
          if (m_midreset) begin
            chk(cycle_pos == 0 && cpu_ph1_en, "R10 restart", cycle_pos, 0);
            m_midreset = 0;
          end
        end
        chk(int'(cycle_pos) == m_pos, "R3 position", cycle_pos, m_pos);
        chk(cpu_ph1_en == (m_pos == 0), "R4 ph1", cpu_ph1_en, m_pos == 0);
        chk(cpu_ph2_en == (m_pos == 16), "R4 ph2", cpu_ph2_en, m_pos == 16);
        chk(vid_a_en == (m_pos == 8), "R5 vid_a", vid_a_en, m_pos == 8);
        chk(vid_b_en == (m_pos == 24), "R5 vid_b", vid_b_en, m_pos == 24);
        chk(slot_en == (m_pos % 4 == 0), "R6 slot_en", slot_en, m_pos % 4 == 0);
        chk(int'(slot_idx) == m_pos / 4, "R6 slot_idx", slot_idx, m_pos / 4);
        if (hires)
          chk(pix_en == (m_pos % 4 == 0), "R7 pix hires", pix_en, m_pos % 4 == 0);
        else
          chk(pix_en == (m_pos % 8 == 0), "R8 pix lores", pix_en, m_pos % 8 == 0);
        if (hires != last_hires)
          chk(pix_en == (hires ? (m_pos % 4 == 0) : (m_pos % 8 == 0)),
              "R9 mode switch", pix_en, hires ? (m_pos % 4 == 0) : (m_pos % 8 == 0));
      end
      last_hires = hires;
    end
  end

  task automatic wait_clks(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #2;
  endtask

  task automatic wait_pos(input int p);
    // advance until the reference is at position p
    do wait_clks(1); while (m_pos != p);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    wait_clks(3);
    rst = 1'b0;                   // R2 release
    wait_clks(3 * CYC);           // R7 hires run
    wait_pos(4);  hires = 1'b0;   // R9 switch where rates disagree
    wait_clks(2 * CYC);           // R8 lores run
    wait_pos(12); hires = 1'b1;   // R9
    wait_pos(20); hires = 1'b0;   // R9
    wait_pos(13); rst = 1'b1;     // R10 mid-cycle reset
    wait_clks(2);
    rst = 1'b0;
    wait_clks(2 * CYC);
    wait_pos(28); hires = 1'b1;
    wait_clks(CYC + 5);
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule